// File: doc/BRIEF.md
# Supply Ready Monitor with Maskable Reset

This block watches the ready indications of five supply circuits: the power-on detector (bit 0), the digital core regulator (bit 1), the analog core regulator (bit 2), the 2.5 V regulator (bit 3) and the bandgap (bit 4). The power-on detector is ready while the main supply is above 1.3 V. Its ready indication also drops when the supply sinks low enough to lose the always-on regulator. The ready inputs arrive already synchronised to the block clock.

Software sees the live ready levels in a read-only status word. Software also sees a sticky loss flag per supply, which it clears by writing 1 to the bit. Loss detection is armed only once all five supplies have been ready together after reset, so the normal power-up ramp leaves no flags behind. An armed loss on a source that the mask register does not block drives a system reset pulse. The pulse lasts a programmable minimum number of cycles.

The register port is a plain single-cycle port. A write takes effect at the clock edge where `reg_wr` is high. Read data follows `reg_addr` combinationally. Word addresses: 0 status, 1 loss flags, 2 reset mask, 3 pulse length.

Top module: `supply_guard`

## Requirements
- R1: Reading address 0 returns the live ready inputs in bits 4:0, in the source order above, with bits 31:5 zero.
- R2: A write to address 0 has no effect: status still reads the live inputs, and no other register changes.
- R3: Before all five ready inputs have been high in the same cycle since reset, no loss flag is set and no reset pulse is produced.
- R4: Once armed, a ready input that is low at a clock edge sets its loss flag (address 1, same bit position) at that edge. The flag stays set after the input returns high.
- R5: Writing address 1 clears each flag whose write-data bit is 1 and leaves the others. If a loss and a clear of the same bit fall in one cycle, the flag stays set.
- R6: The reset mask (address 2, bits 4:0, 1 = source blocked) resets to 0x1F, is fully writable, and reads zero in bits 31:5.
- R7: Once armed, an unmasked source that is low at a clock edge makes `sys_rst` high from that edge on. `sys_rst` then stays high for max(L,1) cycles after the last such edge, where L is the pulse length register.
- R8: A low source whose mask bit is 1 never causes `sys_rst`.
- R9: The loss flag register resets to zero, and its bits 31:5 always read zero.
- R10: The pulse length register (address 3, bits 7:0) resets to 4, is writable, and reads zero in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rdy_in | input | 5 | Synchronised ready levels of the five supplies |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sys_rst | output | 1 | System reset request, active high |

## Verification
Two things can land on the same loss flag in the same clock edge: a software write-1-to-clear and a fresh loss of that supply. The second collision is a new reset trigger arriving while a pulse is still counting down. Both collisions are forced with directed cycles: a clear of all flags while one supply is low, and a second drop partway through a pulse. A seeded random stream then mixes supply drops, mask, length and clear writes. Every cycle the bench compares `sys_rst` and the read word against a cycle model built from the requirements. Set-over-clear decides the first collision, and the pulse length measured from the last trigger decides the second.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  localparam int unsigned N_SRC = 5;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 2;

  typedef enum logic [AW-1:0] {
    ADR_STAT = 2'd0,
    ADR_LOSS = 2'd1,
    ADR_MASK = 2'd2,
    ADR_HOLD = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/supply_loss_tracker.sv
module supply_loss_tracker #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rdy_i,
  input  logic [N-1:0] clr_i,
  output logic         armed_o,
  output logic [N-1:0] flag_o
);
  logic         armed_q;
  logic [N-1:0] flag_q;
  logic [N-1:0] lost;

  assign lost = armed_q ? ~rdy_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      if (&rdy_i) armed_q <= 1'b1;
      flag_q <= (flag_q & ~clr_i) | lost;
    end
  end

  assign armed_o = armed_q;
  assign flag_o  = flag_q;

  // R3: nothing latched before arming
  a_r3_no_flag_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (flag_q == '0));
  // R4/R5: a loss seen while armed is always held at the next edge
  a_r4_loss_latched: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((~$past(rdy_i) & ~flag_q) == '0));
  // R4: once armed, stays armed
  a_r4_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
endmodule

// File: rtl/supply_reset_pulser.sv
module supply_reset_pulser #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [CW-1:0] hold_i,
  output logic          rst_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = (hold_i == '0) ? CW'(1) : hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trig_i)         cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign rst_o = (cnt_q != '0);

  // R7: a trigger always shows on the output at the next edge
  a_r7_trig_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> rst_o);
  // R7: the pulse only ends when no trigger was present
  a_r7_end_untriggered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> !$past(trig_i));
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned          CNT_W    = 8,
  parameter logic [N_SRC-1:0]     MASK_RST = 5'h1F,
  parameter logic [CNT_W-1:0]     HOLD_RST = 8'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rdy_in,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            sys_rst
);
  logic [N_SRC-1:0] mask_q;
  logic [CNT_W-1:0] hold_q;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] clr;
  logic             armed;
  logic             trig;
  logic             wr_mask, wr_hold, wr_loss;
  reg_adr_e         adr;

  wire unused_wdata = ^reg_wdata[DW-1:CNT_W];

  assign adr     = reg_adr_e'(reg_addr);
  assign wr_loss = reg_wr && (adr == ADR_LOSS);
  assign wr_mask = reg_wr && (adr == ADR_MASK);
  assign wr_hold = reg_wr && (adr == ADR_HOLD);
  assign clr     = wr_loss ? reg_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      hold_q <= HOLD_RST;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[N_SRC-1:0];
      if (wr_hold) hold_q <= reg_wdata[CNT_W-1:0];
    end
  end

  supply_loss_tracker #(.N(N_SRC)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy_i   (rdy_in),
    .clr_i   (clr),
    .armed_o (armed),
    .flag_o  (flags)
  );

  assign trig = armed && |(~rdy_in & ~mask_q);

  supply_reset_pulser #(.CW(CNT_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig),
    .hold_i (hold_q),
    .rst_o  (sys_rst)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (adr)
      ADR_STAT: reg_rdata[N_SRC-1:0] = rdy_in;
      ADR_LOSS: reg_rdata[N_SRC-1:0] = flags;
      ADR_MASK: reg_rdata[N_SRC-1:0] = mask_q;
      ADR_HOLD: reg_rdata[CNT_W-1:0] = hold_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R6: mask only moves on a write to its address
  a_r6_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
  // R8: fully masked sources never start a pulse
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) && !sys_rst |=> !sys_rst);
  // R10: length only moves on a write to its address
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hold |=> $stable(hold_q));
endmodule

// File: tb/supply_guard_test.sv
module supply_guard_test;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rdy_in = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_rst;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  bit       m_armed;
  bit [4:0] m_flags, m_mask;
  bit [7:0] m_hold, m_cnt;

  supply_guard uut (
    .clk(clk), .rst_n(rst_n), .rdy_in(rdy_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst(sys_rst)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] a, input logic [4:0] r);
    case (a)
      2'd0: return {27'b0, r};
      2'd1: return {27'b0, m_flags};
      2'd2: return {27'b0, m_mask};
      default: return {24'b0, m_hold};
    endcase
  endfunction

  task automatic model_reset();
    m_armed = 0; m_flags = '0; m_mask = 5'h1F; m_hold = 8'd4; m_cnt = '0;
  endtask

  task automatic model_step(input logic [4:0] r, input logic w, input logic [1:0] a,
                            input logic [31:0] d);
    bit trig;
    bit [4:0] clr;
    trig = m_armed && |(~r & ~m_mask);
    clr  = (w && a == 2'd1) ? d[4:0] : 5'd0;
    m_flags = (m_flags & ~clr) | (m_armed ? ~r : 5'd0);
    if (trig) m_cnt = (m_hold == 0) ? 8'd1 : m_hold;
    else if (m_cnt != 0) m_cnt = m_cnt - 8'd1;
    if (&r) m_armed = 1;
    if (w && a == 2'd2) m_mask = d[4:0];
    if (w && a == 2'd3) m_hold = d[7:0];
  endtask

  // one cycle: drive at negedge, check, then let the edge happen
  task automatic cyc(input logic [4:0] r, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input string tag, input string rtag);
    logic [31:0] e;
    @(negedge clk);
    rdy_in = r; reg_wr = w; reg_addr = a; reg_wdata = d;
    #1;
    e = exp_read(a, r);
    n_run++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, reg_rdata, e);
    end
    n_run++;
    if (sys_rst !== (m_cnt != 0)) begin
      n_fail++;
      $display("FAIL %s: sys_rst got %b expected %b", rtag, sys_rst, (m_cnt != 0));
    end
    @(posedge clk);
    model_step(r, w, a, d);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // reset values: R9 flags, R6 mask, R10 hold, R1 status
    cyc(5'h00, 0, 2'd1, 0, "R9", "R7");
    cyc(5'h03, 0, 2'd2, 0, "R6", "R7");
    cyc(5'h07, 0, 2'd3, 0, "R10", "R7");
    cyc(5'h0B, 0, 2'd0, 0, "R1", "R7");
    // R3: unmask all, supplies ramp partly: no flags, no reset
    cyc(5'h0F, 1, 2'd2, 32'h0, "R6", "R3");
    cyc(5'h1E, 0, 2'd1, 0, "R3", "R3");
    cyc(5'h15, 0, 2'd1, 0, "R3", "R3");
    cyc(5'h00, 0, 2'd1, 0, "R3", "R3");
    // arm
    cyc(5'h1F, 0, 2'd1, 0, "R3", "R3");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    // R4/R7: drop analog regulator for one cycle
    cyc(5'h1B, 0, 2'd1, 0, "R4", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    // R7: retrigger while counting
    cyc(5'h1E, 0, 2'd0, 0, "R1", "R7");
    for (int i = 0; i < 6; i++) cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    // R5: clear all while bandgap low -> bandgap flag stays
    cyc(5'h0F, 1, 2'd1, 32'hFFFF_FFFF, "R5", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R5", "R7");
    cyc(5'h1F, 1, 2'd1, 32'h0000_0001, "R5", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R5", "R7");
    // R2: write status, then observe status and other registers
    cyc(5'h1F, 1, 2'd0, 32'hFFFF_FFFF, "R2", "R7");
    cyc(5'h1A, 0, 2'd0, 0, "R2", "R7");
    cyc(5'h1F, 0, 2'd2, 0, "R2", "R7");
    cyc(5'h1F, 0, 2'd3, 0, "R2", "R7");
    for (int i = 0; i < 6; i++) cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    // R8: mask POR source, drop it: flag yes, reset no
    cyc(5'h1F, 1, 2'd2, 32'h0000_0001, "R6", "R8");
    cyc(5'h1E, 0, 2'd1, 0, "R4", "R8");
    cyc(5'h1E, 0, 2'd1, 0, "R4", "R8");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R8");
    // R10: zero length gives one-cycle pulse, upper bits read zero
    cyc(5'h1F, 1, 2'd3, 32'hFFFF_FF00, "R10", "R7");
    cyc(5'h1F, 0, 2'd3, 0, "R10", "R7");
    cyc(5'h1D, 0, 2'd1, 0, "R4", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    cyc(5'h1F, 0, 2'd1, 0, "R4", "R7");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] r;
      logic w;
      logic [1:0] a;
      logic [31:0] d;
      r = ($urandom % 5 == 0) ? 5'($urandom) : 5'h1F;
      w = ($urandom % 4 == 0);
      a = 2'($urandom);
      d = $urandom;
      if (w && a == 2'd3) d = $urandom % 9;
      case (a)
        2'd0: cyc(r, w, a, d, "R1", "R7");
        2'd1: cyc(r, w, a, d, "R4", "R7");
        2'd2: cyc(r, w, a, d, "R6", "R7");
        default: cyc(r, w, a, d, "R10", "R7");
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule